// File: doc/BRIEF.md
# Word-Wide Single-Block Data Buffer

This block is a one-bank store for 32-bit words. It lets a 32-bit DMA engine or the CPU push one block of data through a single word-wide data register. It sits next to a separate halfword buffer and has its own block length register. That register accepts any 10-bit byte count and returns it unchanged on readback. Internally the count is rounded up to whole words and clamped to between 1 and 128 words. The clamped figure sets how many words the block holds.

Words that are written after the block is full are thrown away, so the stored data is never overwritten. On the read side, a read pointer steps through the stored words one at a time. After the last word of the block has been consumed, the pointer freezes and every further read returns that last word. Neither more reads, new writes nor a new length setting releases this condition. Only a clear pulse from the transfer engine or a hardware reset rewinds both pointers and releases the frozen read. A clear leaves the stored words in place. Two flags, `blk_full_o` and `blk_empty_o`, tell the transfer engine when the block has been fully written and when it has been fully read.

Top module: `word_block_buffer`

## Requirements
- R1: The buffer stores at most 128 words of 32 bits. The number of accepted writes since the last clear never exceeds the effective word count.
- R2: A write with `wr_en_i` high is dropped once the effective word count has been reached. Words already stored keep their values.
- R3: `rd_data_o` shows the word at the read pointer without delay. Each `rd_en_i` pulse advances the pointer. After the last word of the block has been read, the pointer stays put and `rd_data_o` keeps showing the last word.
- R4: Once the read side has frozen on the last word, neither further writes nor a length register write (even one that enlarges the block) moves the read pointer or clears `blk_empty_o`.
- R5: The length register is 10 bits wide. `len_rdata_o` returns exactly the last value written through `len_wr_i`/`len_wdata_i`, including values above 0x200.
- R6: The effective word count is ceil(L/4) clamped to between 1 and 128, where L is the byte length. Examples: L=0 gives 1, L=5 gives 2, L=0x7E gives 32, L=0x1FF gives 128, L=0x3FF gives 128.
- R7: `blk_full_o` is 1 exactly when the number of accepted writes has reached the effective word count. `blk_empty_o` goes to 1 in the cycle after the read that consumes the last word of the block.
- R8: A `clr_i` pulse sets both pointers to word 0 and clears both flags, which releases a frozen read. It does not alter the stored words.
- R9: After hardware reset, `len_rdata_o` is 0x200, both flags are 0 and the read pointer is at word 0.
- R10: In a cycle with `clr_i` high, any write or read issued in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low hardware reset, asynchronous |
| wr_en_i | input | 1 | Word write strobe |
| wr_data_i | input | 32 | Word to store |
| rd_en_i | input | 1 | Word read strobe; consumes the word on `rd_data_o` |
| rd_data_o | output | 32 | Word at the current read pointer |
| len_wr_i | input | 1 | Block length register write strobe |
| len_wdata_i | input | 10 | Byte length to store |
| len_rdata_o | output | 10 | Stored byte length, unmodified |
| clr_i | input | 1 | Clear pulse from the transfer engine |
| blk_full_o | output | 1 | Block completely written |
| blk_empty_o | output | 1 | Last word of block consumed |

## Verification
The assertions check on every cycle that:
- the write count stays within the effective count and holds still when a write is dropped;
- the read pointer stays frozen once the last word is consumed;
- a clear rewinds both sides;
- the length register echoes each written value;
- the effective count stays between 1 and 128.

The data values themselves are left to the bench. Only its scenarios can show them: that overflow words never replace stored ones, that a frozen read repeats the correct last word, that a clear keeps the old contents, and that each length maps to the correct block size.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
   // Storage implementation variants selected by the MEM_STYLE parameter.
   typedef enum logic [0:0] {
      WBB_MEM_FLOPS = 1'b0,
      WBB_MEM_ARRAY = 1'b1
   } wbb_mem_style_e;

   // Rounding of the byte length into a word count.
   localparam int unsigned WBB_BYTES_PER_WORD = 4;
endpackage

// File: rtl/wbb_len_reg.sv
module wbb_len_reg #(
   parameter int unsigned LEN_W     = 10,
   parameter int unsigned MAX_WORDS = 128,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned RESET_LEN = 512
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             len_wr_i,
   input  logic [LEN_W-1:0] len_wdata_i,
   output logic [LEN_W-1:0] len_q_o,
   output logic [CNT_W-1:0] eff_words_o
);
   import wbb_pkg::*;

   localparam int unsigned RAW_W   = LEN_W + 1;
   localparam int unsigned RND_ADD = WBB_BYTES_PER_WORD - 1;
   localparam int unsigned SHIFT   = $clog2(WBB_BYTES_PER_WORD);

   initial begin
      assert (RESET_LEN < (1 << LEN_W)) else $error("RESET_LEN does not fit LEN_W");
      assert (MAX_WORDS < (1 << CNT_W)) else $error("CNT_W too narrow for MAX_WORDS");
   end

   logic [LEN_W-1:0] len_q;
   logic [RAW_W-1:0] raw_words;
   logic [CNT_W-1:0] eff_words;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         len_q <= LEN_W'(RESET_LEN);
      end else if (len_wr_i) begin
         len_q <= len_wdata_i;
      end
   end

   // Round the byte count up to whole words, then clamp into [1, MAX_WORDS].
   always_comb begin
      raw_words = (RAW_W'(len_q) + RAW_W'(RND_ADD)) >> SHIFT;
      if (raw_words == '0) begin
         eff_words = CNT_W'(1);
      end else if (raw_words > RAW_W'(MAX_WORDS)) begin
         eff_words = CNT_W'(MAX_WORDS);
      end else begin
         eff_words = CNT_W'(raw_words);
      end
   end

   assign len_q_o     = len_q;
   assign eff_words_o = eff_words;

   AST_LEN_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      len_wr_i |=> (len_q_o == $past(len_wdata_i)));                          // R5
   AST_EFF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eff_words_o >= CNT_W'(1)) && (eff_words_o <= CNT_W'(MAX_WORDS)));      // R6
endmodule

// File: rtl/wbb_wr_ctrl.sv
module wbb_wr_ctrl #(
   parameter int unsigned MAX_WORDS = 128,
   parameter int unsigned CNT_W     = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             wr_en_i,
   input  logic [CNT_W-1:0] eff_words_i,
   output logic [CNT_W-1:0] wr_cnt_o,
   output logic             wr_fire_o,
   output logic             full_o
);
   logic [CNT_W-1:0] wr_cnt;
   logic             room;

   assign room      = (wr_cnt < eff_words_i);
   assign wr_fire_o = wr_en_i && !clr_i && room;
   assign full_o    = !room;
   assign wr_cnt_o  = wr_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_cnt <= '0;
      end else if (clr_i) begin
         wr_cnt <= '0;
      end else if (wr_fire_o) begin
         wr_cnt <= wr_cnt + CNT_W'(1);
      end
   end

   AST_WR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !clr_i && (wr_cnt >= eff_words_i)) |=> $stable(wr_cnt));    // R2
   AST_WCNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_cnt <= CNT_W'(MAX_WORDS));                                           // R1
   AST_WR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (wr_cnt == '0));                                              // R8
endmodule

// File: rtl/wbb_rd_ctrl.sv
module wbb_rd_ctrl #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned CNT_W  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              rd_en_i,
   input  logic [CNT_W-1:0]  eff_words_i,
   output logic [ADDR_W-1:0] rd_ptr_o,
   output logic              done_o
);
   logic [ADDR_W-1:0] rd_ptr;
   logic              done_q;
   logic              at_last;

   // The pointer is on (or past) the final word of the current block.
   assign at_last = (CNT_W'(rd_ptr) + CNT_W'(1)) >= eff_words_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_ptr <= '0;
         done_q <= 1'b0;
      end else if (clr_i) begin
         rd_ptr <= '0;
         done_q <= 1'b0;
      end else if (rd_en_i) begin
         if (done_q || at_last) begin
            done_q <= 1'b1;
         end else begin
            rd_ptr <= rd_ptr + ADDR_W'(1);
         end
      end
   end

   assign rd_ptr_o = rd_ptr;
   assign done_o   = done_q;

   AST_RD_STUCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_q && !clr_i) |=> ($stable(rd_ptr) && done_q));                    // R4
   AST_RD_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && !clr_i && !done_q && !at_last) |=> (rd_ptr == $past(rd_ptr) + ADDR_W'(1))); // R3
   AST_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> ((rd_ptr == '0) && !done_q));                                 // R8
endmodule

// File: rtl/wbb_storage.sv
module wbb_storage #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned MAX_WORDS = 128,
   parameter int unsigned ADDR_W    = 7,
   parameter bit          MEM_STYLE = 1'b0
) (
   input  logic              clk_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   import wbb_pkg::*;

   logic [DATA_W-1:0] mem_q [MAX_WORDS];

   generate
      if (MEM_STYLE == bit'(WBB_MEM_FLOPS)) begin : g_flops
         // One enable per word: no array write port inferred.
         for (genvar g = 0; g < int'(MAX_WORDS); g++) begin : g_word
            always_ff @(posedge clk_i) begin
               if (we_i && (waddr_i == ADDR_W'(g))) begin
                  mem_q[g] <= wdata_i;
               end
            end
         end
      end else begin : g_array
         always_ff @(posedge clk_i) begin
            if (we_i) begin
               mem_q[waddr_i] <= wdata_i;
            end
         end
      end
   endgenerate

   assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/word_block_buffer.sv
module word_block_buffer #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LEN_W     = 10,
   parameter int unsigned MAX_WORDS = 128,
   parameter int unsigned RESET_LEN = 512,
   parameter bit          MEM_STYLE = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_en_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              len_wr_i,
   input  logic [LEN_W-1:0]  len_wdata_i,
   output logic [LEN_W-1:0]  len_rdata_o,
   input  logic              clr_i,
   output logic              blk_full_o,
   output logic              blk_empty_o
);
   localparam int unsigned ADDR_W = $clog2(MAX_WORDS);
   localparam int unsigned CNT_W  = $clog2(MAX_WORDS + 1);

   initial begin
      assert (MAX_WORDS >= 2) else $error("MAX_WORDS must be at least 2");
      assert (DATA_W >= 8) else $error("DATA_W must be at least 8");
      assert (((MAX_WORDS * 4) - 1) < (1 << LEN_W)) else $error("LEN_W cannot express a full block");
   end

   logic [CNT_W-1:0]  eff_words;
   logic [CNT_W-1:0]  wr_cnt;
   logic              wr_fire;
   logic [ADDR_W-1:0] rd_ptr;

   wbb_len_reg #(
      .LEN_W    (LEN_W),
      .MAX_WORDS(MAX_WORDS),
      .CNT_W    (CNT_W),
      .RESET_LEN(RESET_LEN)
   ) u_len (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .len_wr_i   (len_wr_i),
      .len_wdata_i(len_wdata_i),
      .len_q_o    (len_rdata_o),
      .eff_words_o(eff_words)
   );

   wbb_wr_ctrl #(
      .MAX_WORDS(MAX_WORDS),
      .CNT_W    (CNT_W)
   ) u_wr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr_i),
      .wr_en_i    (wr_en_i),
      .eff_words_i(eff_words),
      .wr_cnt_o   (wr_cnt),
      .wr_fire_o  (wr_fire),
      .full_o     (blk_full_o)
   );

   wbb_rd_ctrl #(
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W)
   ) u_rd (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr_i),
      .rd_en_i    (rd_en_i),
      .eff_words_i(eff_words),
      .rd_ptr_o   (rd_ptr),
      .done_o     (blk_empty_o)
   );

   wbb_storage #(
      .DATA_W   (DATA_W),
      .MAX_WORDS(MAX_WORDS),
      .ADDR_W   (ADDR_W),
      .MEM_STYLE(MEM_STYLE)
   ) u_mem (
      .clk_i  (clk_i),
      .we_i   (wr_fire),
      .waddr_i(wr_cnt[ADDR_W-1:0]),
      .wdata_i(wr_data_i),
      .raddr_i(rd_ptr),
      .rdata_o(rd_data_o)
   );

   AST_CLR_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |-> !wr_fire);                                                    // R10
   AST_STUCK_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(blk_empty_o) && blk_empty_o && !$past(clr_i) && !$past(wr_fire)) |-> $stable(rd_data_o)); // R3
endmodule

// File: tb/word_block_buffer_tb.sv
module word_block_buffer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 10;

   // Each entry: {byte length [17:8], expected effective word count [7:0]}  (R6)
   localparam logic [17:0] VEC [NVEC] = '{
      {10'h000, 8'd1},   {10'h001, 8'd1},   {10'h004, 8'd1},   {10'h005, 8'd2},
      {10'h008, 8'd2},   {10'h07E, 8'd32},  {10'h040, 8'd16},  {10'h1FF, 8'd128},
      {10'h200, 8'd128}, {10'h3FF, 8'd128}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        len_wr = 1'b0;
   logic [9:0]  len_wdata = '0;
   logic [9:0]  len_rdata;
   logic        clr = 1'b0;
   logic        full;
   logic        empty;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   word_block_buffer u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .wr_en_i    (wr_en),
      .wr_data_i  (wr_data),
      .rd_en_i    (rd_en),
      .rd_data_o  (rd_data),
      .len_wr_i   (len_wr),
      .len_wdata_i(len_wdata),
      .len_rdata_o(len_rdata),
      .clr_i      (clr),
      .blk_full_o (full),
      .blk_empty_o(empty)
   );

   function automatic logic [31:0] pat(input int k, input int i);
      return 32'hC0DE_0000 | (32'(k) << 8) | 32'(i & 8'hFF);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic do_rd(output logic [31:0] d);
      @(negedge clk); d = rd_data; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic do_len(input logic [9:0] l);
      @(negedge clk); len_wr = 1'b1; len_wdata = l;
      @(negedge clk); len_wr = 1'b0;
   endtask

   task automatic do_clr();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check("R9 len", 32'(len_rdata), 32'h200);
      check("R9 full", 32'(full), 32'h0);
      check("R9 empty", 32'(empty), 32'h0);

      // Table walk: R1 R2 R3 R5 R6 R7
      for (int k = 0; k < NVEC; k++) begin
         logic [9:0] l;
         int eff;
         l   = VEC[k][17:8];
         eff = int'(VEC[k][7:0]);
         do_clr();
         do_len(l);
         check("R5 readback", 32'(len_rdata), 32'(l));
         for (int i = 0; i < eff + 2; i++) begin
            do_wr(pat(k, i));
            check("R7 R6 full", 32'(full), 32'(i + 1 >= eff));
         end
         for (int i = 0; i < eff + 2; i++) begin
            do_rd(d);
            check("R3 R2 R1 data", d, pat(k, (i < eff) ? i : eff - 1));
            check("R7 empty", 32'(empty), 32'(i + 1 >= eff));
         end
      end

      // R4: frozen read survives a length increase and new writes
      do_clr();
      do_len(10'h008);                 // 2 words
      do_wr(32'h1111_0000);
      do_wr(32'h1111_0001);
      do_rd(d); do_rd(d); do_rd(d);
      check("R3 stuck", d, 32'h1111_0001);
      do_len(10'h010);                 // 4 words
      do_wr(32'h2222_0002);
      check("R4 empty held", 32'(empty), 32'h1);
      do_rd(d);
      check("R4 still last", d, 32'h1111_0001);
      check("R5 grown len", 32'(len_rdata), 32'h010);

      // R8 + R10: clear together with a read releases; data kept
      @(negedge clk); clr = 1'b1; rd_en = 1'b1;
      @(negedge clk); clr = 1'b0; rd_en = 1'b0;
      check("R8 empty cleared", 32'(empty), 32'h0);
      check("R8 full cleared", 32'(full), 32'h0);
      check("R8 R10 word0 kept", rd_data, 32'h1111_0000);

      // R10: write during clear is ignored
      do_len(10'h004);                 // 1 word
      @(negedge clk); clr = 1'b1; wr_en = 1'b1; wr_data = 32'hDEAD_BEEF;
      @(negedge clk); clr = 1'b0; wr_en = 1'b0;
      check("R10 no fill", 32'(full), 32'h0);
      check("R10 data kept", rd_data, 32'h1111_0000);
      do_wr(32'h3333_0000);
      check("R7 full one word", 32'(full), 32'h1);
      do_rd(d);
      check("R3 single word", d, 32'h3333_0000);
      check("R7 empty single", 32'(empty), 32'h1);

      // R9: hardware reset in mid-run
      do_len(10'h3FF);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R9 len after reset", 32'(len_rdata), 32'h200);
      check("R9 flags after reset", {30'b0, full, empty}, 32'h0);
      check("R9 pointer at word 0", rd_data, 32'h3333_0000);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule